// File: doc/BRIEF.md
# Ethernet Receive Station-Address Filter

This block keeps a table of sixteen 48-bit station addresses and decides, for each received frame, which of them the frame's address fields hit. Every entry carries a valid flag and a two-bit select that says whether the entry is compared with the frame's destination address or with its source address. Entry 0 doubles as the station's own individual address. A flow-control (pause) frame is recognised only when its destination equals that entry.

Software programs the table through a 32-bit word interface. Register address bit 0 picks the half, where 0 is the low word and 1 is the high word. The remaining address bits pick the entry. Frame octets arrive on an 8-bit valid/ready byte stream that carries a start-of-frame marker. The block never applies back-pressure: `s_ready` is always 1, and an octet is taken on every cycle in which `s_valid` is high. The result outputs carry no ready signal. Each is a one-cycle pulse that the consumer must take when it appears.

At the first octet of a frame, the live table is copied into a frame-private snapshot. All comparisons for that frame use the snapshot, so a register write made during a frame only affects later frames.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, every entry's valid flag reads as 0, the high word reads 0 in bits 30:18, and no frame produces a match or a pause indication.
- R2: High word layout: bit 31 is the valid flag, bits 17:16 are the select, and bits 15:0 are address bits 47:32. The low word holds address bits 31:0. Reserved bits 30:18 read 0 whatever was written. Reads are combinational on `reg_addr`.
- R3: An entry whose valid flag is 0 never sets its bit in `res_vec`.
- R4: Select 00 compares an entry with the destination address. Select 01 compares it with the source address.
- R5: An entry whose select is 10 or 11 never matches.
- R6: Octets 0–5 form the destination and octets 6–11 form the source. Within each, the first octet is address bits 7:0 and the sixth is bits 47:40. Octet 0 is the octet with `s_sof`=1.
- R7: Each frame that reaches its twelfth octet produces exactly one `res_valid` pulse, in the cycle after that octet is accepted. In the same cycle, `res_vec` holds one bit per matching entry and `res_any` is 1 when any bit is set.
- R8: `res_idx` is the lowest-numbered matching entry. It is 0 when nothing matches.
- R9: `pause_det` pulses in the cycle after octet 13 is accepted, when octets 12 and 13 read 0x88 then 0x08, entry 0 is valid, and the destination equals entry 0's address. The select of entry 0 plays no part in this check.
- R10: A write landing after a frame's first octet does not change that frame's result. It is seen from the next frame onward.
- R11: A `soft_clr` pulse clears all valid flags.
- R12: `s_ready` is always 1. Octets are ignored when `s_valid` is low, before any start-of-frame, and after octet 13. An `s_sof` in the middle of a frame restarts parsing, and the abandoned frame produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low unit reset |
| soft_clr | input | 1 | Software reset pulse; clears all valid flags |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | {entry index, high-word select} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| s_valid | input | 1 | Octet present on `s_data` |
| s_ready | output | 1 | Always 1 |
| s_sof | input | 1 | Marks octet 0 of a frame |
| s_data | input | 8 | Frame octet |
| res_valid | output | 1 | Match result pulse |
| res_any | output | 1 | At least one entry matched |
| res_vec | output | 16 | Per-entry match bits |
| res_idx | output | 4 | Lowest matching entry |
| pause_det | output | 1 | Pause frame addressed to entry 0 |

## Verification
A corrupt table word shows up at `reg_rdata` in the same cycle its address is presented. It also shows up as a wrong or missing `res_vec` bit one cycle after the twelfth octet of the next frame. A wrong octet counter shows up either as a pulse at the wrong cycle or as a missing or extra pulse, which the scoreboard catches at the frame where it happens. A stale or early snapshot shows up only on a frame with a write during the frame, so such a frame is followed by a second frame with the same addresses.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  localparam int MAC_W      = 48;
  localparam int OCT_W      = 8;
  localparam int WORD_W     = 32;
  localparam int HDR_OCTETS = 14;
  localparam int MAC_OCTETS = MAC_W / OCT_W;
  localparam int CNT_W      = $clog2(HDR_OCTETS + 2);
  localparam logic [1:0]  SEL_DST    = 2'b00;
  localparam logic [1:0]  SEL_SRC    = 2'b01;
  localparam logic [15:0] PAUSE_TYPE = 16'h8808;
endpackage

// File: rtl/rxaf_regfile.sv
module rxaf_regfile
  import rxaf_pkg::*;
#(
  parameter int NUM_ENT = 16,
  localparam int IDX_W  = $clog2(NUM_ENT)
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         soft_clr,
  input  logic                         wr,
  input  logic [IDX_W:0]               addr,
  input  logic [WORD_W-1:0]            wdata,
  output logic [WORD_W-1:0]            rdata,
  input  logic                         snap,
  output logic [NUM_ENT-1:0]           snap_v,
  output logic [NUM_ENT-1:0][1:0]      snap_sel,
  output logic [NUM_ENT-1:0][MAC_W-1:0] snap_mac
);
  logic [NUM_ENT-1:0]            live_v;
  logic [NUM_ENT-1:0][1:0]       live_sel;
  logic [NUM_ENT-1:0][MAC_W-1:0] live_mac;
  logic [IDX_W-1:0]              ent;
  logic                          hi;
  logic                          unused_rsvd;

  assign ent         = addr[IDX_W:1];
  assign hi          = addr[0];
  assign unused_rsvd = ^wdata[30:18];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                live_v      <= '0;
    else if (soft_clr)         live_v      <= '0;
    else if (wr && hi)         live_v[ent] <= wdata[31];
  end

  always_ff @(posedge clk) begin
    if (wr) begin
      if (hi) begin
        live_sel[ent]              <= wdata[17:16];
        live_mac[ent][MAC_W-1:32]  <= wdata[15:0];
      end else begin
        live_mac[ent][31:0]        <= wdata;
      end
    end
  end

  always_comb begin
    if (hi) rdata = {live_v[ent], 13'd0, live_sel[ent], live_mac[ent][MAC_W-1:32]};
    else    rdata = live_mac[ent][31:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    snap_v <= '0;
    else if (snap) snap_v <= live_v;
  end

  always_ff @(posedge clk) begin
    if (snap) begin
      snap_sel <= live_sel;
      snap_mac <= live_mac;
    end
  end

  AST_SOFT_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) soft_clr |=> (live_v == '0)); // R11
  AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) !snap |=> $stable(snap_v)); // R10
endmodule

// File: rtl/rxaf_parser.sv
module rxaf_parser
  import rxaf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  input  logic             s_sof,
  input  logic [OCT_W-1:0] s_data,
  output logic             snap,
  output logic [MAC_W-1:0] dst,
  output logic [MAC_W-1:0] src,
  output logic             addr_done,
  output logic             type_done,
  output logic [15:0]      type_word
);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(2*MAC_OCTETS - 1);
  localparam logic [CNT_W-1:0] TYPE_HI   = CNT_W'(2*MAC_OCTETS);
  localparam logic [CNT_W-1:0] TYPE_LO   = CNT_W'(2*MAC_OCTETS + 1);
  localparam logic [CNT_W-1:0] DONE      = CNT_W'(HDR_OCTETS);

  logic [CNT_W-1:0] cnt, idx;
  logic             take;
  logic [MAC_W-1:0] dst_q, src_q;
  logic [OCT_W-1:0] type_hi_q;

  assign take = s_valid && (s_sof || cnt < DONE);
  assign idx  = s_sof ? '0 : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '1;
    else if (take) cnt <= idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      for (int k = 0; k < MAC_OCTETS; k++) begin
        if (idx == CNT_W'(k))              dst_q[OCT_W*k +: OCT_W] <= s_data;
        if (idx == CNT_W'(k + MAC_OCTETS)) src_q[OCT_W*k +: OCT_W] <= s_data;
      end
      if (idx == TYPE_HI) type_hi_q <= s_data;
    end
  end

  always_comb begin
    src = src_q;
    src[MAC_W-1 -: OCT_W] = s_data;
  end

  assign dst       = dst_q;
  assign snap      = take && s_sof;
  assign addr_done = take && idx == LAST_ADDR;
  assign type_done = take && idx == TYPE_LO;
  assign type_word = {type_hi_q, s_data};

  AST_CNT_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) cnt != '0); // R12
endmodule

// File: rtl/rxaf_match.sv
module rxaf_match
  import rxaf_pkg::*;
#(
  parameter int NUM_ENT = 16,
  localparam int IDX_W  = $clog2(NUM_ENT)
)(
  input  logic [NUM_ENT-1:0]            ent_v,
  input  logic [NUM_ENT-1:0][1:0]       ent_sel,
  input  logic [NUM_ENT-1:0][MAC_W-1:0] ent_mac,
  input  logic [MAC_W-1:0]              dst,
  input  logic [MAC_W-1:0]              src,
  output logic [NUM_ENT-1:0]            hit,
  output logic [IDX_W-1:0]              hit_idx,
  output logic                          own_dst
);
  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    logic dst_eq, src_eq;
    assign dst_eq = ent_mac[g] == dst;
    assign src_eq = ent_mac[g] == src;
    assign hit[g] = ent_v[g] && ((ent_sel[g] == SEL_DST && dst_eq) ||
                                 (ent_sel[g] == SEL_SRC && src_eq));
  end

  always_comb begin
    hit_idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--)
      if (hit[i]) hit_idx = IDX_W'(i);
  end

  assign own_dst = ent_v[0] && ent_mac[0] == dst;
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxaf_pkg::*;
#(
  parameter int NUM_ENT = 16,
  localparam int IDX_W  = $clog2(NUM_ENT)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_clr,
  input  logic               reg_wr,
  input  logic [IDX_W:0]     reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic               s_sof,
  input  logic [OCT_W-1:0]   s_data,
  output logic               res_valid,
  output logic               res_any,
  output logic [NUM_ENT-1:0] res_vec,
  output logic [IDX_W-1:0]   res_idx,
  output logic               pause_det
);
  localparam logic [NUM_ENT-1:0] ONE = NUM_ENT'(1);

  logic                          snap, addr_done, type_done, own_dst, pause_arm;
  logic [MAC_W-1:0]              dst, src;
  logic [15:0]                   type_word;
  logic [NUM_ENT-1:0]            snap_v, hit, rsvd_mask;
  logic [NUM_ENT-1:0][1:0]       snap_sel;
  logic [NUM_ENT-1:0][MAC_W-1:0] snap_mac;
  logic [IDX_W-1:0]              hit_idx;

  assign s_ready = 1'b1;

  rxaf_regfile #(.NUM_ENT(NUM_ENT)) u_regs (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr(reg_wr),
    .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata), .snap(snap),
    .snap_v(snap_v), .snap_sel(snap_sel), .snap_mac(snap_mac)
  );

  rxaf_parser u_parse (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_sof(s_sof), .s_data(s_data),
    .snap(snap), .dst(dst), .src(src), .addr_done(addr_done),
    .type_done(type_done), .type_word(type_word)
  );

  rxaf_match #(.NUM_ENT(NUM_ENT)) u_match (
    .ent_v(snap_v), .ent_sel(snap_sel), .ent_mac(snap_mac),
    .dst(dst), .src(src), .hit(hit), .hit_idx(hit_idx), .own_dst(own_dst)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_any   <= 1'b0;
      res_vec   <= '0;
      res_idx   <= '0;
      pause_arm <= 1'b0;
      pause_det <= 1'b0;
    end else begin
      res_valid <= addr_done;
      pause_det <= type_done && pause_arm && type_word == PAUSE_TYPE;
      if (addr_done) begin
        res_vec   <= hit;
        res_any   <= |hit;
        res_idx   <= hit_idx;
        pause_arm <= own_dst;
      end else if (snap) begin
        pause_arm <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_rsvd
    assign rsvd_mask[g] = snap_sel[g][1];
  end

  AST_RES_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) res_valid |=> !res_valid); // R7
  AST_IDX_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && res_any) |-> res_vec[res_idx]); // R8
  AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> ((res_vec & ((ONE << res_idx) - ONE)) == '0)); // R8
  AST_INVALID_SILENT: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> ((res_vec & ~snap_v) == '0)); // R3
  AST_RSVD_SEL_SILENT: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> ((res_vec & rsvd_mask) == '0)); // R5
  AST_PAUSE_NEEDS_OWN: assert property (@(posedge clk) disable iff (!rst_n) pause_det |-> snap_v[0]); // R9
endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_clr = 1'b0, reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        s_valid = 1'b0, s_sof = 1'b0, s_ready;
  logic [7:0]  s_data = '0;
  logic        res_valid, res_any, pause_det;
  logic [15:0] res_vec;
  logic [3:0]  res_idx;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [15:0] m_v, s_v;
  logic [1:0]  m_sel [16];
  logic [47:0] m_mac [16];
  logic [1:0]  s_sel [16];
  logic [47:0] s_mac [16];

  logic [15:0] q_vec [$];
  logic [3:0]  q_idx [$];

  always #2 clk = ~clk;

  rx_addr_filter u_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .s_valid(s_valid), .s_ready(s_ready), .s_sof(s_sof), .s_data(s_data),
    .res_valid(res_valid), .res_any(res_any), .res_vec(res_vec),
    .res_idx(res_idx), .pause_det(pause_det)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int ent, input bit hi, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {ent[3:0], hi}; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (hi) begin m_v[ent] = d[31]; m_sel[ent] = d[17:16]; m_mac[ent][47:32] = d[15:0]; end
    else m_mac[ent][31:0] = d;
  endtask

  task automatic rd_chk(input int ent, input bit hi, input logic [31:0] mask,
                        input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = {ent[3:0], hi};
    #1;
    chk((reg_rdata & mask) == exp, req, reg_rdata & mask, exp);
  endtask

  // R6: octet k<6 is dst[8k+:8], octets 6..11 are src, 12..13 are type (high first)
  task automatic send_frame(input logic [47:0] da, input logic [47:0] sa, input logic [15:0] typ,
                            input bit gaps, input int wr_at, input int went, input logic [31:0] wd,
                            input string req);
    logic [7:0]  b [14];
    logic [15:0] ev;
    logic [3:0]  ei;
    bit          ep;
    s_v = m_v;
    for (int i = 0; i < 16; i++) begin s_sel[i] = m_sel[i]; s_mac[i] = m_mac[i]; end
    ev = '0; ei = '0;
    for (int i = 15; i >= 0; i--)
      if (s_v[i] && ((s_sel[i] == 2'b00 && s_mac[i] == da) || (s_sel[i] == 2'b01 && s_mac[i] == sa))) begin
        ev[i] = 1'b1; ei = i[3:0];
      end
    ep = s_v[0] && s_mac[0] == da && typ == 16'h8808;
    q_vec.push_back(ev); q_idx.push_back(ei);
    for (int k = 0; k < 6; k++) begin b[k] = da[8*k +: 8]; b[k+6] = sa[8*k +: 8]; end
    b[12] = typ[15:8]; b[13] = typ[7:0];
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      s_valid = 1'b1; s_sof = (k == 0); s_data = b[k];
      reg_wr = (k == wr_at);
      if (k == wr_at) begin
        reg_addr = {went[3:0], 1'b1}; reg_wdata = wd;
        m_v[went] = wd[31]; m_sel[went] = wd[17:16]; m_mac[went][47:32] = wd[15:0];
      end
      if (gaps && k != 13) begin
        @(negedge clk);
        s_valid = 1'b0; s_data = 8'hEE; reg_wr = 1'b0;
      end
    end
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; reg_wr = 1'b0;
    chk(pause_det == ep, {req, " R9 pause"}, pause_det, ep);
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && res_valid && !done) begin
      if (q_vec.size() == 0) begin
        chk(1'b0, "R7/R12 unexpected result", res_vec, 0);
      end else begin
        logic [15:0] ev;
        logic [3:0]  ei;
        ev = q_vec.pop_front(); ei = q_idx.pop_front();
        chk(res_vec == ev, "R4 vec", res_vec, ev);
        chk(res_any == (ev != 0), "R7 any", res_any, ev != 0);
        chk(res_idx == ei, "R8 idx", res_idx, ei);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [47:0] A0 = 48'h0A1B2C3D4E5F;
  localparam logic [47:0] A3 = 48'h112233445566;
  localparam logic [47:0] A7 = 48'h777766665555;
  localparam logic [47:0] A9 = 48'h00AA00BB00CC;
  localparam logic [47:0] NX = 48'hFFEEDDCCBBAA;

  initial begin
    m_v = '0;
    for (int i = 0; i < 16; i++) begin m_sel[i] = 2'b00; m_mac[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk(0, 1'b1, 32'hFFFC_0000, 32'h0, "R1 valid after reset");
    rd_chk(7, 1'b1, 32'hFFFC_0000, 32'h0, "R1 valid after reset");
    chk(res_valid == 1'b0 && pause_det == 1'b0, "R1 outputs idle", {res_valid, pause_det}, 0);
    chk(s_ready == 1'b1, "R12 ready", s_ready, 1);
    send_frame(NX, NX, 16'h8808, 1'b0, -1, 0, 0, "R1 empty table");
    // R2 layout and reserved bits
    wr(0, 1'b1, {1'b1, 13'h1FFF, 2'b00, A0[47:32]});
    wr(0, 1'b0, A0[31:0]);
    rd_chk(0, 1'b1, 32'hFFFF_FFFF, {1'b1, 13'h0, 2'b00, A0[47:32]}, "R2 high word");
    rd_chk(0, 1'b0, 32'hFFFF_FFFF, A0[31:0], "R2 low word");
    // R4/R6 destination match on entry 0
    send_frame(A0, NX, 16'h0800, 1'b0, -1, 0, 0, "R6 dst");
    // R4 source match on entry 3
    wr(3, 1'b0, A3[31:0]); wr(3, 1'b1, {1'b1, 13'h0, 2'b01, A3[47:32]});
    rd_chk(3, 1'b1, 32'hFFFF_FFFF, {1'b1, 13'h0, 2'b01, A3[47:32]}, "R2 select field");
    send_frame(NX, A3, 16'h0800, 1'b0, -1, 0, 0, "R4 src");
    send_frame(A0, A3, 16'h0800, 1'b0, -1, 0, 0, "R8 two hits");
    // R3/R5 invalid and reserved selects holding A0
    wr(5, 1'b0, A0[31:0]); wr(5, 1'b1, {1'b1, 13'h0, 2'b10, A0[47:32]});
    wr(8, 1'b0, A0[31:0]); wr(8, 1'b1, {1'b1, 13'h0, 2'b11, A0[47:32]});
    wr(6, 1'b0, A0[31:0]); wr(6, 1'b1, {1'b0, 13'h0, 2'b00, A0[47:32]});
    send_frame(A0, NX, 16'h0800, 1'b0, -1, 0, 0, "R3 R5");
    // R8 lowest of 9 and 12
    wr(9, 1'b0, A9[31:0]);  wr(9, 1'b1, {1'b1, 13'h0, 2'b00, A9[47:32]});
    wr(12, 1'b0, A9[31:0]); wr(12, 1'b1, {1'b1, 13'h0, 2'b00, A9[47:32]});
    send_frame(A9, NX, 16'h0800, 1'b0, -1, 0, 0, "R8 lowest");
    send_frame(NX, NX, 16'h0800, 1'b0, -1, 0, 0, "R7 no match");
    // R9 pause
    send_frame(A0, NX, 16'h8808, 1'b0, -1, 0, 0, "R9 own");
    send_frame(A0, NX, 16'h8809, 1'b0, -1, 0, 0, "R9 wrong type");
    send_frame(A9, NX, 16'h8808, 1'b0, -1, 0, 0, "R9 other dst");
    wr(0, 1'b1, {1'b1, 13'h0, 2'b01, A0[47:32]});
    send_frame(A0, NX, 16'h8808, 1'b0, -1, 0, 0, "R9 select ignored");
    wr(0, 1'b1, {1'b1, 13'h0, 2'b00, A0[47:32]});
    // R10 write during frame
    wr(7, 1'b0, A7[31:0]);
    send_frame(A7, NX, 16'h0800, 1'b0, 3, 7, {1'b1, 13'h0, 2'b00, A7[47:32]}, "R10 same frame");
    send_frame(A7, NX, 16'h0800, 1'b0, -1, 0, 0, "R10 next frame");
    // R12 gaps, stray octets, restart
    send_frame(A3, A3, 16'h0800, 1'b1, -1, 0, 0, "R12 gaps");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); s_valid = 1'b1; s_sof = 1'b0; s_data = 8'h5F;
    end
    @(negedge clk); s_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(q_vec.size() == 0, "R12 trailing octets ignored", q_vec.size(), 0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); s_valid = 1'b1; s_sof = (k == 0); s_data = A0[8*k +: 8];
    end
    send_frame(A9, NX, 16'h0800, 1'b0, -1, 0, 0, "R12 restart");
    // R11 soft clear
    @(negedge clk); soft_clr = 1'b1;
    @(negedge clk); soft_clr = 1'b0;
    m_v = '0;
    rd_chk(0, 1'b1, 32'h8000_0000, 32'h0, "R11 cleared");
    rd_chk(7, 1'b1, 32'h8000_0000, 32'h0, "R11 cleared");
    send_frame(A0, A3, 16'h8808, 1'b0, -1, 0, 0, "R11 no match");
    repeat (4) @(negedge clk);
    chk(q_vec.size() == 0, "R7 every frame reported", q_vec.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule